// File: doc/BRIEF.md
# Multiword Estimate-and-Correct Divider

This block divides a 64-bit unsigned dividend by a 32-bit unsigned divisor and returns a 32-bit quotient and a 32-bit remainder. It treats both operands as strings of 16-bit digits. The quotient is built one digit at a time, high digit first.

For each digit, an internal narrow divider gives a first guess. It divides a 32-bit slice of the running remainder by the divisor's upper 16-bit digit plus one. That divisor is never smaller than the true one, so the guess can only be low. The block then subtracts guess times divisor from the running remainder. After that, a correction loop takes the shifted divisor away once per cycle and raises the digit by one each time, until another subtraction would go negative. The narrow divider is an iterative restoring unit that produces one quotient bit per cycle. Its divisor is 17 bits wide, so an upper digit of 0xFFFF plus one does not wrap to zero.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. Back-pressure rules:
- An input beat is taken only on a cycle where both `in_valid` and `in_ready` are high.
- `in_ready` stays low from the accepting edge until the result has been taken.
- A result beat stays on the port, unchanged, until `out_ready` is high.

Two problems are reported with flags instead of a division:
- A zero divisor.
- A dividend whose upper 32 bits are at least the divisor, which means the quotient would not fit in 32 bits.

Latency for a normal division depends on the data.

Top module: `mw_div`

## Requirements
- R1: `in_ready` is high only while no operation is in progress and no result is waiting. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` and `out_valid` are never high together.
- R2: For a nonzero divisor whose value exceeds the upper 32 bits of the dividend, the result satisfies two conditions. First, `out_quotient*divisor + out_remainder` equals the dividend. Second, `out_remainder` is less than the divisor. Both flags read 0.
- R3: When the divisor is 0, the result has `out_div_zero`=1, `out_overflow`=0, and quotient and remainder 0. `out_valid` is high in the cycle right after acceptance.
- R4: When the divisor is nonzero and the upper 32 bits of the dividend are greater than or equal to it, the result has `out_overflow`=1, `out_div_zero`=0, and quotient and remainder 0. `out_valid` is high in the cycle right after acceptance. When those bits are strictly less than the divisor, `out_overflow` is 0.
- R5: While `out_valid` is high and `out_ready` is low, the result and both flags hold steady. The result retires on the edge where `out_ready` is high, and `in_ready` is high in the next cycle.
- R6: Divisors whose upper 16-bit digit is 0xFFFF divide exactly (as in R2).
- R7: The quotient extremes 0 and 0xFFFFFFFF are produced exactly.
- R8: `in_valid` and operand changes while an operation is in progress have no effect on the result being computed.
- R9: After reset, `in_ready` is 1 and `out_valid` is 0.
- R10: Divisors whose upper 16-bit digit is 0 or 1 still give exact results, even though the first guesses then fall far short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block is idle and will take a beat |
| in_dividend | input | 64 | Unsigned dividend |
| in_divisor | input | 32 | Unsigned divisor |
| out_valid | output | 1 | Result beat offered |
| out_ready | input | 1 | Downstream takes the result |
| out_quotient | output | 32 | Quotient, or 0 on an error |
| out_remainder | output | 32 | Remainder, or 0 on an error |
| out_div_zero | output | 1 | Divisor was zero |
| out_overflow | output | 1 | Quotient would exceed 32 bits |

## Verification
The bench aims at these corner cases:
- **Upper divisor digit of 0xFFFF.** A 16-bit adder for "digit plus one" would divide by zero here and return garbage.
- **Upper divisor digit of 0 or 1.** The guesses land tens of thousands of units low. A correction loop that ran a fixed number of times, or only once, would leave the quotient short and the remainder far above the divisor.
- **Overflow boundary.** The bench uses upper dividend bits exactly equal to the divisor. A strict-greater comparison would instead start a division whose digits overflow.
- **Quotient extremes.** The bench checks a quotient of all ones (dividend equal to the divisor squared) and a quotient of zero.
- **Blocked results and operands sent during a busy period.** A design that re-sampled its inputs or dropped a blocked result would return the wrong operands' answer.

// File: rtl/mwdiv_pkg.sv
package mwdiv_pkg;

  // Control sequence of the divider. High-digit states come first, then low-digit states.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HEST,
    ST_HWAIT,
    ST_HMUL,
    ST_HFIX,
    ST_LEST,
    ST_LWAIT,
    ST_LMUL,
    ST_LFIX,
    ST_OUT
  } mwdiv_state_e;

  localparam int unsigned MWDIV_DIG_W_DEFAULT = 16;

endpackage

// File: rtl/mwdiv_trialsub.sv
// Wide subtract that also reports whether the difference is non-negative.
module mwdiv_trialsub #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] diff,
  output logic         nonneg
);
  logic borrow;

  assign {borrow, diff} = {1'b0, a} - {1'b0, b};
  assign nonneg = ~borrow;

endmodule

// File: rtl/mwdiv_digit_mul.sv
// One quotient digit times the full divisor, built as a sum of shifted partial products.
module mwdiv_digit_mul #(
  parameter int unsigned A_W = 16,
  parameter int unsigned B_W = 32
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] p
);
  localparam int unsigned P_W = A_W + B_W;

  logic [P_W-1:0] part [A_W];

  for (genvar gi = 0; gi < A_W; gi++) begin : g_part
    assign part[gi] = a[gi] ? (P_W'(b) << gi) : '0;
  end

  always_comb begin
    p = '0;
    for (int i = 0; i < A_W; i++) begin
      p = p + part[i];
    end
  end

endmodule

// File: rtl/mwdiv_narrow.sv
// Iterative restoring divider: one quotient bit per cycle, NUM_W cycles per divide.
module mwdiv_narrow #(
  parameter int unsigned NUM_W = 32,
  parameter int unsigned DEN_W = 17,
  parameter int unsigned Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quo
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);
  localparam int unsigned T_W   = DEN_W + 1;

  logic [NUM_W-1:0] num_r;
  logic [DEN_W-1:0] den_r;
  logic [DEN_W-1:0] part_r;
  logic [Q_W-1:0]   quo_r;
  logic [CNT_W-1:0] cnt_r;
  logic             busy_r;
  logic             done_r;

  logic [T_W-1:0] trial;
  logic [T_W-1:0] trial_diff;
  logic           fits;

  assign trial = {part_r, num_r[NUM_W-1]};

  mwdiv_trialsub #(.W(T_W)) u_step (
    .a      (trial),
    .b      ({1'b0, den_r}),
    .diff   (trial_diff),
    .nonneg (fits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_r  <= '0;
      den_r  <= '0;
      part_r <= '0;
      quo_r  <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else if (start) begin
      num_r  <= num;
      den_r  <= den;
      part_r <= '0;
      quo_r  <= '0;
      cnt_r  <= CNT_W'(NUM_W);
      busy_r <= 1'b1;
      done_r <= 1'b0;
    end else if (busy_r) begin
      num_r  <= {num_r[NUM_W-2:0], 1'b0};
      quo_r  <= {quo_r[Q_W-2:0], fits};
      part_r <= fits ? trial_diff[DEN_W-1:0] : trial[DEN_W-1:0];
      cnt_r  <= cnt_r - 1'b1;
      if (cnt_r == CNT_W'(1)) begin
        busy_r <= 1'b0;
        done_r <= 1'b1;
      end
    end else begin
      done_r <= 1'b0;
    end
  end

  assign busy = busy_r;
  assign done = done_r;
  assign quo  = quo_r;

endmodule

// File: rtl/mw_div.sv
module mw_div
  import mwdiv_pkg::*;
#(
  parameter int unsigned DIG_W = MWDIV_DIG_W_DEFAULT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [4*DIG_W-1:0]   in_dividend,
  input  logic [2*DIG_W-1:0]   in_divisor,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*DIG_W-1:0]   out_quotient,
  output logic [2*DIG_W-1:0]   out_remainder,
  output logic                 out_div_zero,
  output logic                 out_overflow
);
  localparam int unsigned DW2 = 2 * DIG_W;
  localparam int unsigned DW3 = 3 * DIG_W;
  localparam int unsigned DW4 = 4 * DIG_W;

  mwdiv_state_e st;

  logic [DW4-1:0]   rem_r;
  logic [DW2-1:0]   d_r;
  logic [DIG_W-1:0] qh_r;
  logic [DIG_W-1:0] ql_r;
  logic [DW2-1:0]   q_out_r;
  logic [DW2-1:0]   r_out_r;
  logic             dz_r;
  logic             ov_r;

  logic             hi_phase;
  logic             accept;
  logic             nd_start;
  logic [DW2-1:0]   nd_num;
  logic [DIG_W:0]   nd_den;
  logic             nd_busy;
  logic             nd_done;
  logic [DIG_W-1:0] nd_quo;
  logic [DIG_W-1:0] mul_dig;
  logic [DW3-1:0]   prod;
  logic [DW4-1:0]   sub_b;
  logic [DW4-1:0]   sub_diff;
  logic             sub_ok;

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_OUT);
  assign accept    = in_valid && in_ready;

  assign hi_phase = (st == ST_HEST) || (st == ST_HWAIT) || (st == ST_HMUL) || (st == ST_HFIX);

  // Narrow estimate: a 32-bit slice of the running remainder over the upper divisor digit + 1 (17 bits).
  assign nd_start = (st == ST_HEST) || (st == ST_LEST);
  assign nd_num   = hi_phase ? rem_r[DW4-1:DW2] : rem_r[DW3-1:DIG_W];
  assign nd_den   = {1'b0, d_r[DW2-1:DIG_W]} + (DIG_W+1)'(1);

  mwdiv_narrow #(
    .NUM_W (DW2),
    .DEN_W (DIG_W + 1),
    .Q_W   (DIG_W)
  ) u_narrow (
    .clk   (clk),
    .rst_n (rst_n),
    .start (nd_start),
    .num   (nd_num),
    .den   (nd_den),
    .busy  (nd_busy),
    .done  (nd_done),
    .quo   (nd_quo)
  );

  assign mul_dig = hi_phase ? qh_r : ql_r;

  mwdiv_digit_mul #(.A_W(DIG_W), .B_W(DW2)) u_mul (
    .a (mul_dig),
    .b (d_r),
    .p (prod)
  );

  // One shared wide subtractor serves both the product removal and the correction steps.
  always_comb begin
    unique case (st)
      ST_HMUL: sub_b = {prod, {DIG_W{1'b0}}};
      ST_HFIX: sub_b = {{DIG_W{1'b0}}, d_r, {DIG_W{1'b0}}};
      ST_LMUL: sub_b = {{DIG_W{1'b0}}, prod};
      default: sub_b = {{DW2{1'b0}}, d_r};
    endcase
  end

  mwdiv_trialsub #(.W(DW4)) u_sub (
    .a      (rem_r),
    .b      (sub_b),
    .diff   (sub_diff),
    .nonneg (sub_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rem_r   <= '0;
      d_r     <= '0;
      qh_r    <= '0;
      ql_r    <= '0;
      q_out_r <= '0;
      r_out_r <= '0;
      dz_r    <= 1'b0;
      ov_r    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            rem_r <= in_dividend;
            d_r   <= in_divisor;
            qh_r  <= '0;
            ql_r  <= '0;
            if (in_divisor == '0) begin
              dz_r    <= 1'b1;
              ov_r    <= 1'b0;
              q_out_r <= '0;
              r_out_r <= '0;
              st      <= ST_OUT;
            end else if (in_dividend[DW4-1:DW2] >= in_divisor) begin
              dz_r    <= 1'b0;
              ov_r    <= 1'b1;
              q_out_r <= '0;
              r_out_r <= '0;
              st      <= ST_OUT;
            end else begin
              dz_r <= 1'b0;
              ov_r <= 1'b0;
              st   <= ST_HEST;
            end
          end
        end
        ST_HEST:  st <= ST_HWAIT;
        ST_HWAIT: begin
          if (nd_done) begin
            qh_r <= nd_quo;
            st   <= ST_HMUL;
          end
        end
        ST_HMUL: begin
          rem_r <= sub_diff;
          st    <= ST_HFIX;
        end
        ST_HFIX: begin
          if (sub_ok) begin
            rem_r <= sub_diff;
            qh_r  <= qh_r + 1'b1;
          end else begin
            st <= ST_LEST;
          end
        end
        ST_LEST:  st <= ST_LWAIT;
        ST_LWAIT: begin
          if (nd_done) begin
            ql_r <= nd_quo;
            st   <= ST_LMUL;
          end
        end
        ST_LMUL: begin
          rem_r <= sub_diff;
          st    <= ST_LFIX;
        end
        ST_LFIX: begin
          if (sub_ok) begin
            rem_r <= sub_diff;
            ql_r  <= ql_r + 1'b1;
          end else begin
            q_out_r <= {qh_r, ql_r};
            r_out_r <= rem_r[DW2-1:0];
            st      <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign out_quotient  = q_out_r;
  assign out_remainder = r_out_r;
  assign out_div_zero  = dz_r;
  assign out_overflow  = ov_r;

  // The narrow unit is idle whenever a new estimate is launched.
  always_comb begin
    if (rst_n && nd_start) begin
      assert (!nd_busy);  // R2
    end
  end

endmodule

// File: rtl/mw_div_chk.sv
module mw_div_chk #(
  parameter int unsigned DIG_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [4*DIG_W-1:0] in_dividend,
  input logic [2*DIG_W-1:0] in_divisor,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2*DIG_W-1:0] out_quotient,
  input logic [2*DIG_W-1:0] out_remainder,
  input logic               out_div_zero,
  input logic               out_overflow
);
  localparam int unsigned DW2 = 2 * DIG_W;
  localparam int unsigned DW4 = 4 * DIG_W;

  logic [DW4-1:0] x_cap;
  logic [DW2-1:0] d_cap;
  logic           bad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_cap <= '0;
      d_cap <= '0;
    end else if (in_valid && in_ready) begin
      x_cap <= in_dividend;
      d_cap <= in_divisor;
    end
  end

  assign bad_in = (in_divisor == '0) || (in_dividend[DW4-1:DW2] >= in_divisor);

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);  // R1

  AST_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_div_zero && !out_overflow) |->
      ((DW4'(out_quotient) * DW4'(d_cap) + DW4'(out_remainder)) == x_cap) &&
      (out_remainder < d_cap));  // R2

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && d_cap == '0) |->
      (out_div_zero && !out_overflow && out_quotient == '0 && out_remainder == '0));  // R3

  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && d_cap != '0 && x_cap[DW4-1:DW2] >= d_cap) |->
      (out_overflow && !out_div_zero && out_quotient == '0));  // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && x_cap[DW4-1:DW2] < d_cap) |-> !out_overflow);  // R4

  AST_FAST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && bad_in) |=> out_valid);  // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_quotient) && $stable(out_remainder) &&
       $stable(out_div_zero) && $stable(out_overflow)));  // R5

  AST_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);  // R5

endmodule

bind mw_div mw_div_chk #(.DIG_W(DIG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_dividend   (in_dividend),
  .in_divisor    (in_divisor),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_quotient  (out_quotient),
  .out_remainder (out_remainder),
  .out_div_zero  (out_div_zero),
  .out_overflow  (out_overflow)
);

// File: tb/mw_div_tb.sv
module mw_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam int NVEC       = 8;

  // {dividend, divisor}
  localparam logic [95:0] VEC [NVEC] = '{
    {64'h0000_0001_2345_6789, 32'h8000_0001},
    {64'h7FFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF},  // R6
    {64'hFFFF_FFFE_0000_0001, 32'hFFFF_FFFF},  // R7 quotient all ones
    {64'h0000_0000_0000_1234, 32'h1234_5678},  // R7 quotient zero
    {64'h1234_5678_9ABC_DEF0, 32'h9ABC_0001},
    {64'h0123_4567_89AB_CDEF, 32'h0200_0000},
    {64'h0000_00FF_FFFF_FFFF, 32'h0001_0000},  // R10 upper digit 1
    {64'h0000_0000_FFFF_FFFF, 32'h0000_0003}   // R10 upper digit 0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_dividend = '0;
  logic [31:0] in_divisor = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_quotient;
  logic [31:0] out_remainder;
  logic        out_div_zero;
  logic        out_overflow;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  mw_div u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_dividend   (in_dividend),
    .in_divisor    (in_divisor),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_quotient  (out_quotient),
    .out_remainder (out_remainder),
    .out_div_zero  (out_div_zero),
    .out_overflow  (out_overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Offers one operation, waits for its result; waits counts negedges after acceptance.
  task automatic do_op(input logic [63:0] x, input logic [31:0] d,
                       output logic [31:0] q, output logic [31:0] r,
                       output logic dz, output logic ov, output int waits);
    @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = x;
    in_divisor  = d;
    @(negedge clk);
    in_valid = 1'b0;
    waits = 0;
    while (!out_valid) begin
      @(negedge clk);
      waits++;
    end
    q  = out_quotient;
    r  = out_remainder;
    dz = out_div_zero;
    ov = out_overflow;
    if (out_ready) @(negedge clk);
  endtask

  initial begin
    logic [31:0] q, r, q0;
    logic        dz, ov;
    int          w;
    logic [63:0] x;
    logic [31:0] d;

    // R9 reset state
    #(CLK_PERIOD*2 + 1);
    check("R9 in_ready", 64'(in_ready), 64'd1);
    check("R9 out_valid", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R6 R7 R10 vector table
    for (int i = 0; i < NVEC; i++) begin
      x = VEC[i][95:32];
      d = VEC[i][31:0];
      do_op(x, d, q, r, dz, ov, w);
      check($sformatf("R2 quotient vec%0d", i), 64'(q), x / {32'd0, d});
      check($sformatf("R2 remainder vec%0d", i), 64'(r), x % {32'd0, d});
      check($sformatf("R2 flags vec%0d", i), {62'd0, dz, ov}, 64'd0);
    end

    // R3 zero divisor, valid in the cycle after acceptance
    do_op(64'h1234_0000_0000_0001, 32'd0, q, r, dz, ov, w);
    check("R3 latency", 64'(w), 64'd0);
    check("R3 flags", {62'd0, dz, ov}, 64'd2);
    check("R3 result", {q, r}, 64'd0);

    // R4 overflow boundary: upper half equal to divisor
    do_op(64'h0000_5000_0000_0000, 32'h0000_5000, q, r, dz, ov, w);
    check("R4 latency", 64'(w), 64'd0);
    check("R4 flags", {62'd0, dz, ov}, 64'd1);
    check("R4 result", {q, r}, 64'd0);
    // R4 just below the boundary divides normally
    do_op(64'h0000_4FFF_FFFF_FFFF, 32'h0000_5000, q, r, dz, ov, w);
    check("R4 no overflow", 64'(ov), 64'd0);
    check("R4 below quotient", 64'(q), 64'h0000_4FFF_FFFF_FFFF / 64'h5000);

    // R5 back-pressure: result held until out_ready
    out_ready = 1'b0;
    do_op(64'h0000_0003_0000_0007, 32'h8000_0000, q0, r, dz, ov, w);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R5 held valid", 64'(out_valid), 64'd1);
      check("R5 held quotient", 64'(out_quotient), 64'(q0));
    end
    check("R5 quotient", 64'(q0), 64'h0000_0003_0000_0007 / 64'h8000_0000);
    check("R1 no ready while held", 64'(in_ready), 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R5 retired", 64'(out_valid), 64'd0);
    check("R5 ready after retire", 64'(in_ready), 64'd1);

    // R8 operands offered while busy are ignored
    @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = 64'h0000_1111_2222_3333;
    in_divisor  = 32'h4444_0005;
    @(negedge clk);
    in_dividend = 64'h0;
    in_divisor  = 32'd0;
    while (!out_valid) begin
      if (in_ready) begin
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL R1 busy in_ready: act=1 exp=0");
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R8 quotient", 64'(out_quotient), 64'h0000_1111_2222_3333 / 64'h4444_0005);
    check("R8 remainder", 64'(out_remainder), 64'h0000_1111_2222_3333 % 64'h4444_0005);
    check("R8 flags", {62'd0, out_div_zero, out_overflow}, 64'd0);
    @(negedge clk);
    check("R8 nothing queued", 64'(out_valid), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule